// File: doc/BRIEF.md
# PHY Change-Event Status and Interrupt Register

This block is a 16-bit register that records four kinds of change reported by the physical-layer logic of a network port: link state, duplex mode, auto-negotiation state and line speed. Each change arrives as a single-cycle pulse and sets a sticky flag. A summary flag records that any change happened. Each flag has a mask bit, and a master enable gates a single active-high interrupt line.

Software uses a simple synchronous port. Writes set only the control field: the four per-source masks, the master enable and a self-test switch. Reading clears the flags. `rdata_o` always shows the current register contents, so the value seen in the read cycle is the value before the clear. A second read shows the cleared state. When self-test is on, writing 1 to a mask bit also raises the matching flag, as if the event had occurred. Interrupt wiring can then be tested without line activity.

Top module: `phy_irq_status_reg`

## Requirements
- R1: After reset, every register bit reads 0 and `irq_o` is 0.
- R2: Bits 15:14 and 7:5 always read 0, whatever was written to them.
- R3: A write updates bits 13:8 from `wdata_i` and leaves bits 4:0 unchanged, except for the forcing of R8.
- R4: An event pulse sets its flag in the cycle after the pulse, whatever the state of its mask bit. The mapping is link to bit 1, duplex to bit 2, auto-negotiation to bit 3 and speed to bit 4. The flag stays 1 until a read clears it.
- R5: Bit 0 becomes 1 in the cycle after any of the flags in bits 4:1 is set, and it stays 1 until a read.
- R6: During a read cycle, `rdata_o` shows the value held before the clear. After the read edge, bits 4:0 are 0 and bits 13:8 keep their value.
- R7: If an event pulse arrives in the same cycle as a read, its flag and bit 0 are 1 after the read edge.
- R8: If bit 13 already holds 1, a write with 1s in bits 12:9 sets the matching flags in bits 4:1 (bit 9 to bit 1, up to bit 12 to bit 4) and sets bit 0.
- R9: If bit 13 holds 0, a write never sets any of bits 4:0.
- R10: `irq_o` is 1 exactly when bit 8 is 1 and at least one flag in bits 4:1 is 1 while its mask bit (flag bit + 8) is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe; clears the flags at the clock edge |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Current register contents |
| link_evt_i | input | 1 | Link state change pulse |
| duplex_evt_i | input | 1 | Duplex mode change pulse |
| aneg_evt_i | input | 1 | Auto-negotiation state change pulse |
| speed_evt_i | input | 1 | Speed change pulse |
| irq_o | output | 1 | Masked interrupt, active high |

## Verification
`rdata_o` is combinational from the stored bits, so a corrupted flag, mask or test bit shows up at the next read. It also reaches `irq_o` in the same cycle whenever its mask and the master enable are on. A clear that fails to happen is seen on the second read of each pair. A lost event shows up as a 0 in the read that follows a pulse timed to coincide with a read. A wrong test-mode gate shows up one cycle after a mask write, as flags that should not be set, or that should be set and are not.

// File: rtl/phy_isr_pkg.sv
package phy_isr_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned N_SRC    = 4;
  localparam int unsigned GSTS_BIT = 0;
  localparam int unsigned STS_LSB  = 1;
  localparam int unsigned GEN_BIT  = 8;
  localparam int unsigned EN_LSB   = 9;
  localparam int unsigned TEST_BIT = EN_LSB + N_SRC;
endpackage

// File: rtl/isr_sticky_bit.sv
module isr_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // a set in the clearing cycle survives the clear (R7)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= set_i;
    else            q_o <= q_o | set_i;
  end
endmodule

// File: rtl/isr_ctrl_reg.sv
module isr_ctrl_reg #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] en_d_i,
  input  logic             gen_d_i,
  input  logic             test_d_i,
  output logic [N_SRC-1:0] en_o,
  output logic             gen_o,
  output logic             test_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      gen_o  <= 1'b0;
      test_o <= 1'b0;
    end else if (wr_i) begin
      en_o   <= en_d_i;
      gen_o  <= gen_d_i;
      test_o <= test_d_i;
    end
  end
endmodule

// File: rtl/isr_irq_comb.sv
module isr_irq_comb #(
  parameter int unsigned N_SRC = 4
) (
  input  logic [N_SRC-1:0] sts_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             gen_i,
  output logic             irq_o
);
  assign irq_o = gen_i & (|(sts_i & en_i));
endmodule

// File: rtl/phy_irq_status_reg.sv
module phy_irq_status_reg
  import phy_isr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             link_evt_i,
  input  logic             duplex_evt_i,
  input  logic             aneg_evt_i,
  input  logic             speed_evt_i,
  output logic             irq_o
);
  logic [N_SRC-1:0] evt, frc, set, sts_q, en_q;
  logic             gen_q, test_q, gsts_q;
  logic             unused_wdata;

  assign unused_wdata = ^{wdata_i[REG_W-1:TEST_BIT+1], wdata_i[GEN_BIT-1:STS_LSB+N_SRC],
                          wdata_i[STS_LSB+N_SRC-1:0]};

  assign evt = {speed_evt_i, aneg_evt_i, duplex_evt_i, link_evt_i};
  // forcing uses the test bit already held, not the one being written (R8)
  assign frc = (wr_i && test_q) ? wdata_i[EN_LSB +: N_SRC] : '0;
  assign set = evt | frc;

  isr_ctrl_reg #(.N_SRC(N_SRC)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .en_d_i  (wdata_i[EN_LSB +: N_SRC]),
    .gen_d_i (wdata_i[GEN_BIT]),
    .test_d_i(wdata_i[TEST_BIT]),
    .en_o    (en_q),
    .gen_o   (gen_q),
    .test_o  (test_q)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_sts
    isr_sticky_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set[i]),
      .clr_i (rd_i),
      .q_o   (sts_q[i])
    );
  end

  isr_sticky_bit u_gsts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (|set),
    .clr_i (rd_i),
    .q_o   (gsts_q)
  );

  isr_irq_comb #(.N_SRC(N_SRC)) u_irq (
    .sts_i(sts_q),
    .en_i (en_q),
    .gen_i(gen_q),
    .irq_o(irq_o)
  );

  always_comb begin
    rdata_o                     = '0;
    rdata_o[TEST_BIT]           = test_q;
    rdata_o[EN_LSB +: N_SRC]    = en_q;
    rdata_o[GEN_BIT]            = gen_q;
    rdata_o[STS_LSB +: N_SRC]   = sts_q;
    rdata_o[GSTS_BIT]           = gsts_q;
  end
endmodule

// File: rtl/phy_irq_status_reg_chk.sv
module phy_irq_status_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_i,
  input logic        wr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic        link_evt_i,
  input logic        duplex_evt_i,
  input logic        aneg_evt_i,
  input logic        speed_evt_i,
  input logic        irq_o
);
  logic [3:0] evt;
  assign evt = {speed_evt_i, aneg_evt_i, duplex_evt_i, link_evt_i};

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[15:14] == 2'b00 && rdata_o[7:5] == 3'b000);

  assert_write_ctrl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rdata_o[13:8] == $past(wdata_i[13:8]));

  assert_flag_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o[4:0] & $past(rdata_o[4:0])) == $past(rdata_o[4:0]));

  assert_event_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != 4'h0) |=> (rdata_o[4:1] & $past(evt)) == $past(evt));

  assert_summary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != 4'h0) |=> rdata_o[0]);

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && evt == 4'h0) |=> rdata_o[4:0] == 5'h00 && $stable(rdata_o[13:8]));

  assert_no_force_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdata_o[13] && evt == 4'h0 && !rd_i) |=> rdata_o[4:0] == $past(rdata_o[4:0]));

  assert_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (rdata_o[8] && ((rdata_o[4:1] & rdata_o[12:9]) != 4'h0)));
endmodule

bind phy_irq_status_reg phy_irq_status_reg_chk u_chk (.*);

// File: tb/phy_irq_status_reg_bench.sv
`timescale 1ns/1ps
module phy_irq_status_reg_bench;
  typedef struct {
    logic [15:0] d;
    logic        irq;
    string       req;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        link_evt_i = 1'b0, duplex_evt_i = 1'b0, aneg_evt_i = 1'b0, speed_evt_i = 1'b0;
  logic        irq_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  item_t sb[$];

  // bench model of the register, built from the requirements
  logic [3:0] m_sts = '0, m_en = '0;
  logic       m_g = 1'b0, m_gen = 1'b0, m_test = 1'b0;

  always #2 clk_i = ~clk_i;

  phy_irq_status_reg u_phy_irq_status_reg (.*);

  function automatic logic [15:0] m_val();
    return {2'b00, m_test, m_en, m_gen, 3'b000, m_sts, m_g};
  endfunction

  function automatic logic m_irq();
    return m_gen & (|(m_sts & m_en));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; reads push their expected value
  task automatic cyc(input logic rd, input logic wr, input logic [15:0] wd,
                     input logic [3:0] evt, input string req);
    logic [3:0] frc, set;
    @(posedge clk_i); #1;
    rd_i = rd; wr_i = wr; wdata_i = wd;
    {speed_evt_i, aneg_evt_i, duplex_evt_i, link_evt_i} = evt;
    if (rd) sb.push_back('{d: m_val(), irq: m_irq(), req: req});
    frc = (wr && m_test) ? wd[12:9] : 4'h0;
    set = evt | frc;
    m_sts = rd ? set : (m_sts | set);
    m_g   = rd ? (|set) : (m_g | (|set));
    if (wr) begin
      m_en = wd[12:9]; m_gen = wd[8]; m_test = wd[13];
    end
  endtask

  task automatic rd(input string req);
    cyc(1'b1, 1'b0, 16'h0, 4'h0, req);
  endtask

  task automatic wr(input logic [15:0] d);
    cyc(1'b0, 1'b1, d, 4'h0, "");
  endtask

  task automatic ev(input logic [3:0] e);
    cyc(1'b0, 1'b0, 16'h0, e, "");
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && rd_i && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk({it.req, " rdata"}, rdata_o, it.d);
      chk({it.req, " irq"}, {15'h0, irq_o}, {15'h0, it.irq});
    end
  end

  initial begin
    #10;
    chk("R1 reset rdata", rdata_o, 16'h0000);
    chk("R1 reset irq", {15'h0, irq_o}, 16'h0000);
    rst_ni = 1'b1;
    rd("R1");
    wr(16'hC0FF);                     // reserved and flag bits only
    rd("R2 R3 R9");
    wr(16'h1F00);                     // all masks, master enable, test off
    rd("R3 R9");
    ev(4'b0001);                      // link
    rd("R4 R5 R10");
    rd("R6 second read");
    wr(16'h0000);
    ev(4'b1000);                      // speed with masks off
    rd("R4 R10 masked");
    cyc(1'b1, 1'b0, 16'h0, 4'b0010, "R7 read with duplex pulse");
    rd("R7");
    wr(16'h1E00);                     // masks on, master off
    ev(4'b0100);                      // aneg
    rd("R10 master off");
    ev(4'b0100);
    wr(16'h1F00);
    rd("R10 master on");
    wr(16'h2000);                     // test on
    wr(16'h2A00);                     // force aneg and link
    rd("R8 forced");
    rd("R6 test bit kept");
    ev(4'b1111);
    rd("R4 all sources");
    cyc(1'b0, 1'b1, 16'h3FFF, 4'h0, "");
    rd("R8 R10 all forced");
    cyc(1'b0, 1'b0, 16'h0, 4'h0, "");
    @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule